// File: doc/BRIEF.md
# Transform Edge Arithmetic Unit

This unit sits on both sides of an 8x8 block-transform pipeline. On the way in, it prepares each 12-bit sample for the transform. In one forward mode it first takes a 9-bit auxiliary sample away from the input and limits the difference to the 9-bit signed range. On the way out, it shapes each transform result. In one inverse mode it adds a 9-bit auxiliary sample, saturates the sum and forces negative values to zero. Other modes only narrow the data or pass it through. The matrix arithmetic between the two sides lies outside this unit.

Each side works on blocks of 64 samples. A block starts on the cycle its start strobe is seen high while that side is idle, and the 3-bit mode code is captured on that same cycle. The input side takes its code from the producer. The output side takes its code from the transform, together with the result stream. For the add mode, the auxiliary stream is sent ahead of time and delayed inside the unit, so that each addend meets its result.

Top module: `xform_edge_unit`

## Requirements
- R1: A start strobe is accepted only when its side is idle. The mode code captured with it governs all 64 samples of that block. Start strobes and codes seen during the other 63 cycles have no effect.
- R2: Mode 000 (forward, plain): one cycle after sampling, `pre_out` = {din[11:3], 3'b000}. The low three input bits and `aux_in` are ignored.
- R3: Mode 100 (forward, subtract): `pre_out[11:3]` = din[11:3] − aux_in, both read as signed. The difference is saturated to −256..255 by the sign of the true difference, and `pre_out[2:0]` = 0.
- R4: Inverse modes 001, 101 and 111 pass all 12 bits of `din` to `pre_out` after one cycle.
- R5: Mode 001 (inverse, plain): `dout` = {xf_res[11:3], 3'b000}, signed and unclipped.
- R6: Mode 101 (inverse, add and clip): `dout[11:3]` is xf_res[11:3] + aux, saturated to 9 bits and then clipped to zero if negative. `dout[2:0]` = 0. The aux value used is the one sampled 4 clock edges before the edge that updates `dout` with that result.
- R7: Mode 111 (inverse, clip only): `dout[11:3]` = xf_res[11:3], clipped to zero if negative. `aux_in` is ignored.
- R8: Modes 010 (filter) and 011 (transpose) use 9-bit data on both sides: `pre_out` = {din[11:3], 000} and `dout` = {xf_res[11:3], 000}.
- R9: Forward modes 000 and 100 pass all 12 bits of `xf_res` to `dout` and ignore `aux_in` on the output side.
- R10: The reserved code 110 passes data through unchanged on both sides, with no subtract, add or clip.
- R11: After reset, and on every cycle that carries no block sample, `pre_out` and `dout` are zero.
- R12: `xf_res` sampled at a clock edge appears on `dout` after the following edge. `din` sampled at an edge appears on `pre_out` after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Input-side block start strobe |
| mode_in | input | 3 | Input-side mode code, captured with blk_start |
| din | input | 12 | Input sample, signed |
| aux_in | input | 9 | Auxiliary sample, aligned with bits 11..3 |
| pre_out | output | 12 | Prepared sample to the transform |
| res_start | input | 1 | Output-side block start strobe |
| res_mode | input | 3 | Output-side mode code, captured with res_start |
| xf_res | input | 12 | Transform result sample, signed |
| dout | output | 12 | Final output sample |

## Verification
Every mode code is run on both sides with two data patterns. The first is an exhaustive 8x8 grid of corner values for data and auxiliary: −256, −255, −1, 0, 1, 100, 254 and 255. This grid tells saturation at each rail apart from clipping and from plain narrowing. The second is a scattered sweep across the whole range, with nonzero low bits. It exposes wrong bit slicing and any auxiliary leakage in modes that must ignore it. Because the auxiliary values change on every sample, an add whose delay is one cycle off yields different sums and shows up. Stray start strobes carrying a different code inside a block show whether the captured mode is held.

// File: rtl/xform_edge_unit.sv
module xform_edge_unit #(
  parameter int DW = 12,
  parameter int AW = 9,
  parameter int BLK = 64,
  parameter int AUX_LEAD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_start,
  input  logic [2:0]    mode_in,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] aux_in,
  output logic [DW-1:0] pre_out,
  input  logic          res_start,
  input  logic [2:0]    res_mode,
  input  logic [DW-1:0] xf_res,
  output logic [DW-1:0] dout
);
  localparam int LW = DW - AW;
  localparam int CW = $clog2(BLK);
  localparam logic [CW-1:0] LAST = CW'(BLK - 1);
  localparam logic [2:0] M_FWD      = 3'b000;
  localparam logic [2:0] M_FWD_SUB  = 3'b100;
  localparam logic [2:0] M_INV      = 3'b001;
  localparam logic [2:0] M_INV_ADD  = 3'b101;
  localparam logic [2:0] M_INV_CLIP = 3'b111;
  localparam logic [2:0] M_FILT     = 3'b010;
  localparam logic [2:0] M_TRN      = 3'b011;
  localparam logic [AW-1:0] SMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] SMIN = {1'b1, {(AW-1){1'b0}}};

  function automatic logic [AW-1:0] sat(input logic [AW:0] v);
    if (v[AW] != v[AW-1]) return v[AW] ? SMIN : SMAX;
    return v[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] clip(input logic [AW-1:0] v);
    return v[AW-1] ? '0 : v;
  endfunction

  // input side
  logic [CW-1:0] i_cnt;
  logic [2:0]    i_mode, i_sel;
  logic          i_take, i_live;
  logic [AW-1:0] d9;
  logic [AW:0]   diff;
  logic [DW-1:0] pre_nx;

  assign i_take = blk_start && (i_cnt == '0);
  assign i_live = i_take || (i_cnt != '0);
  assign i_sel  = i_take ? mode_in : i_mode;
  assign d9     = din[DW-1:LW];
  assign diff   = {d9[AW-1], d9} - {aux_in[AW-1], aux_in};

  always_comb begin
    case (i_sel)
      M_FWD_SUB:            pre_nx = {sat(diff), {LW{1'b0}}};
      M_FWD, M_FILT, M_TRN: pre_nx = {d9, {LW{1'b0}}};
      default:              pre_nx = din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_cnt   <= '0;
      i_mode  <= M_FWD;
      pre_out <= '0;
    end else begin
      if (i_take) begin
        i_cnt  <= LAST;
        i_mode <= mode_in;
      end else if (i_cnt != '0) begin
        i_cnt <= i_cnt - CW'(1);
      end
      pre_out <= i_live ? pre_nx : '0;
    end
  end

  // output side
  logic [CW-1:0] o_cnt;
  logic [2:0]    o_mode, o_sel, m_q;
  logic          o_take, o_live, v_q;
  logic [DW-1:0] r_q, post_nx;
  logic [AW-1:0] aux_d [AUX_LEAD];
  logic [AW-1:0] r9, a9, add_s;
  logic [AW:0]   sum;

  assign o_take = res_start && (o_cnt == '0);
  assign o_live = o_take || (o_cnt != '0);
  assign o_sel  = o_take ? res_mode : o_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_d[0] <= '0;
    else        aux_d[0] <= aux_in;
  end

  for (genvar k = 1; k < AUX_LEAD; k++) begin : g_aux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) aux_d[k] <= '0;
      else        aux_d[k] <= aux_d[k-1];
    end
  end

  assign r9    = r_q[DW-1:LW];
  assign a9    = aux_d[AUX_LEAD-1];
  assign sum   = {r9[AW-1], r9} + {a9[AW-1], a9};
  assign add_s = sat(sum);

  always_comb begin
    case (m_q)
      M_INV, M_FILT, M_TRN: post_nx = {r9, {LW{1'b0}}};
      M_INV_ADD:            post_nx = {clip(add_s), {LW{1'b0}}};
      M_INV_CLIP:           post_nx = {clip(r9), {LW{1'b0}}};
      default:              post_nx = r_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_cnt  <= '0;
      o_mode <= M_FWD;
      m_q    <= M_FWD;
      v_q    <= 1'b0;
      r_q    <= '0;
      dout   <= '0;
    end else begin
      if (o_take) begin
        o_cnt  <= LAST;
        o_mode <= res_mode;
      end else if (o_cnt != '0) begin
        o_cnt <= o_cnt - CW'(1);
      end
      v_q  <= o_live;
      m_q  <= o_sel;
      r_q  <= xf_res;
      dout <= v_q ? post_nx : '0;
    end
  end
endmodule

// File: rtl/xform_edge_unit_chk.sv
module xform_edge_unit_chk #(
  parameter int DW = 12,
  parameter int AW = 9,
  parameter int BLK = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   blk_start,
  input logic [$clog2(BLK)-1:0] i_cnt,
  input logic [$clog2(BLK)-1:0] o_cnt,
  input logic [2:0]             i_mode,
  input logic [2:0]             o_mode,
  input logic [2:0]             m_q,
  input logic                   v_q,
  input logic [DW-1:0]          pre_out,
  input logic [DW-1:0]          dout
);
  localparam int LW = DW - AW;

  assert_in_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (i_cnt != '0) |=> (i_mode == $past(i_mode)));
  assert_out_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (o_cnt != '0) |=> (o_mode == $past(o_mode)));
  assert_in_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((i_cnt == '0) && !blk_start) |=> (pre_out == '0));
  assert_out_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |=> (dout == '0));
  assert_sub_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((i_cnt != '0) && (i_mode == 3'b100)) |=> (pre_out[LW-1:0] == '0));
  assert_add_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (m_q == 3'b101)) |=> !dout[DW-1]);
  assert_clip_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (m_q == 3'b111)) |=> !dout[DW-1]);
  assert_inv_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (m_q == 3'b001)) |=> (dout[LW-1:0] == '0));
endmodule

bind xform_edge_unit xform_edge_unit_chk #(.DW(DW), .AW(AW), .BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .i_cnt(i_cnt), .o_cnt(o_cnt),
  .i_mode(i_mode), .o_mode(o_mode), .m_q(m_q), .v_q(v_q),
  .pre_out(pre_out), .dout(dout)
);

// File: tb/tb_xform_edge_unit.sv
module tb_xform_edge_unit;
  logic        clk = 0, rst_n = 0;
  logic        blk_start = 0, res_start = 0;
  logic [2:0]  mode_in = 0, res_mode = 0;
  logic [11:0] din = 0, xf_res = 0;
  logic [8:0]  aux_in = 0;
  logic [11:0] pre_out, dout;
  int total = 0, fails = 0;
  bit done = 0;

  xform_edge_unit dut (.*);

  always #5 clk = ~clk;

  function automatic int sat9(int v);
    return (v > 255) ? 255 : (v < -256) ? -256 : v;
  endfunction

  function automatic int corner(int k);
    case (k)
      0: return -256; 1: return -255; 2: return -1; 3: return 0;
      4: return 1;    5: return 100;  6: return 254; default: return 255;
    endcase
  endfunction

  function automatic logic [11:0] pre_exp(logic [2:0] md, logic [11:0] d, logic [8:0] a);
    int x = $signed(d[11:3]);
    int y = $signed(a);
    int s;
    case (md)
      3'b100: begin s = sat9(x - y); return {s[8:0], 3'b000}; end
      3'b000, 3'b010, 3'b011: return {d[11:3], 3'b000};
      default: return d;
    endcase
  endfunction

  function automatic logic [11:0] out_exp(logic [2:0] md, logic [11:0] r, logic [8:0] a);
    int x = $signed(r[11:3]);
    int y = $signed(a);
    int s;
    case (md)
      3'b001, 3'b010, 3'b011: return {r[11:3], 3'b000};
      3'b101: begin s = sat9(x + y); if (s < 0) s = 0; return {s[8:0], 3'b000}; end
      3'b111: begin s = (x < 0) ? 0 : x; return {s[8:0], 3'b000}; end
      default: return r;
    endcase
  endfunction

  function automatic string pre_tag(logic [2:0] md);
    case (md)
      3'b000: return "R2"; 3'b100: return "R3";
      3'b010, 3'b011: return "R8"; 3'b110: return "R10";
      default: return "R4";
    endcase
  endfunction

  function automatic string out_tag(logic [2:0] md);
    case (md)
      3'b001: return "R5"; 3'b101: return "R6"; 3'b111: return "R7";
      3'b010, 3'b011: return "R8"; 3'b110: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic make(int pat, int j, output logic [11:0] d, output logic [8:0] a);
    int x, y;
    if (pat == 0) begin x = corner(j % 8); y = corner(j / 8); end
    else begin x = ((j * 37 + 11) % 512) - 256; y = ((j * 91 + 5) % 512) - 256; end
    d = {x[8:0], 3'(j * 5 + 3)};
    a = y[8:0];
  endtask

  task automatic run_pre(logic [2:0] md, int pat, bit stray);
    logic [11:0] dq [64];
    logic [8:0]  aq [64];
    string tag = stray ? "R1" : pre_tag(md);
    for (int j = 0; j < 64; j++) make(pat, j, dq[j], aq[j]);
    for (int c = 0; c <= 65; c++) begin
      @(negedge clk);
      if (c >= 1 && c <= 64) check({tag, "/R12"}, pre_out, pre_exp(md, dq[c-1], aq[c-1]));
      if (c == 65) check("R11", pre_out, 12'h000);
      if (c < 64) begin
        din = dq[c]; aux_in = aq[c];
        blk_start = (c == 0) || stray;
        mode_in = (c == 0) ? md : (md ^ 3'b101);
      end else begin
        din = 0; aux_in = 0; blk_start = 0; mode_in = 0;
      end
    end
  endtask

  task automatic run_post(logic [2:0] md, int pat, bit stray);
    logic [11:0] rq [64];
    logic [8:0]  aq [64];
    string tag = stray ? "R1" : out_tag(md);
    for (int j = 0; j < 64; j++) make(pat, j, rq[j], aq[j]);
    for (int c = -3; c <= 66; c++) begin
      @(negedge clk);
      if (c >= 2 && c <= 65) check({tag, "/R12"}, dout, out_exp(md, rq[c-2], aq[c-2]));
      if (c == 66) check("R11", dout, 12'h000);
      aux_in = (c + 3 >= 0 && c + 3 < 64) ? aq[c+3] : 9'h000;
      if (c >= 0 && c < 64) begin
        xf_res = rq[c];
        res_start = (c == 0) || stray;
        res_mode = (c == 0) ? md : (md ^ 3'b110);
      end else begin
        xf_res = 0; res_start = 0; res_mode = 0;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", pre_out, 12'h000);
    check("R11", dout, 12'h000);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 2; p++) begin
        run_pre(3'(m), p, 0);
        run_post(3'(m), p, 0);
      end
    end
    run_pre(3'b100, 1, 1);
    run_pre(3'b001, 0, 1);
    run_post(3'b101, 1, 1);
    run_post(3'b000, 0, 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule